// File: doc/BRIEF.md
# Instruction Repeat Sequencer

This block drives the repetition of one issued instruction. Software programs a 13-bit repeat value through a 16-bit register on a byte-addressable register bus. The value is the number of executions minus one. When the pipeline issues a repeat-enabled instruction, it raises `start`. The sequencer then sets its busy flag and asserts `exec` once per clock for each iteration. It lowers the repeat value by one after every pulse. After the last pulse it clears the flag and gives a one-cycle `done` pulse. `stall` holds the front of the pipeline while iterations remain after the current one.

The repeat value and the busy flag share one register. On the bus, a write that enables only one byte lane clears the other lane's bits. The busy flag and the unused bits are read-only and read as zero when inactive. A register write made while a repeat runs is held back and applied when the repeat finishes. A second `start` during a repeat is dropped. The block does not know what the repeated instruction does.

Top module: `rptc_top`

## Requirements
- R1: After reset the register reads 0000h and `exec`, `stall` and `done` are low.
- R2: The register holds the repeat value in bits 12..0 and the busy flag in bit 15. Bits 15..13 ignore writes, and bits 14..13 always read 0.
- R3: In idle, a write with `reg_be`=01 loads bits 7..0 and clears bits 12..8. A write with `reg_be`=10 loads bits 12..8 and clears bits 7..0. A write with `reg_be`=11 loads bits 12..0. A write with `reg_be`=00 changes nothing.
- R4: When `start` is sampled in idle with value N, the flag reads 1 from the next cycle. `exec` is then high for exactly N+1 consecutive cycles.
- R5: While the flag is set, the repeat value read back falls by one each cycle, from N down to 0.
- R6: In the cycle after the last `exec` cycle, `done` is high for exactly one cycle, the flag reads 0, and the repeat value reads 0 unless a write was held back.
- R7: `stall` is high in every `exec` cycle except the last, and low otherwise.
- R8: A `start` sampled while the flag is set has no effect: no extra `exec` cycle follows and the block stays idle after `done`.
- R9: A write made while the flag is set does not change the value read back during the repeat. It is applied when the repeat completes, and the last such write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register read value |
| start | input | 1 | A repeat-enabled instruction has been issued |
| exec | output | 1 | Execute the instruction in this cycle |
| stall | output | 1 | More iterations remain after this one |
| done | output | 1 | One-cycle pulse after the last iteration |

## Verification
A wrong repeat value shows at once on `reg_rdata`, which the bench reads every cycle of a repeat. A wrong value also shows as a wrong number of `exec` cycles and a `done` pulse in the wrong place, at the latest N+2 cycles after `start`. A flaw in the byte-lane decode appears on the first read after a single-lane write. A write that leaks into a running repeat breaks the one-per-cycle countdown in the very next cycle.

// File: rtl/rptc_pkg.sv
// Package: shared types for the repeat sequencer.
// Assumes: it is compiled before every other file of the block.
package rptc_pkg;
    // Sequencer state: idle, or running iterations.
    typedef enum logic {
        RPT_IDLE = 1'b0,
        RPT_RUN  = 1'b1
    } rpt_state_e;
endpackage

// File: rtl/rptc_wrdec.sv
// Module: rptc_wrdec
// Turns a bus write into the repeat value it would produce.
// A count bit is loaded from the write data when its byte lane is
// enabled and is cleared when its lane is not, so one-lane writes
// clear the other lane.
// Assumes: REG_W is a multiple of 8 and CNT_W < REG_W.
module rptc_wrdec #(
    parameter int unsigned CNT_W = 13,
    parameter int unsigned REG_W = 16,
    localparam int unsigned NLANE = REG_W / 8
) (
    input  logic             wr,
    input  logic [NLANE-1:0] be,
    input  logic [REG_W-1:0] wdata,
    output logic             wr_vld,
    output logic [CNT_W-1:0] wr_cnt
);
    // A write counts only when at least one lane is enabled.
    assign wr_vld = wr & (|be);

    // Per count bit: take the data bit if its lane is enabled, else zero.
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign wr_cnt[i] = be[i / 8] & wdata[i];
    end

    // Bits above the count field are read-only; data there is dropped.
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:CNT_W];
endmodule

// File: rtl/rptc_pend.sv
// Module: rptc_pend
// Holds one register write that arrived while a repeat was running.
// A newer write replaces an older one. The entry is cleared when the
// sequencer consumes it at completion.
// Assumes: capture and consume are never both requested for a write
// that must survive; the top routes a same-cycle write straight through.
module rptc_pend #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             consume,
    output logic             pend_vld,
    output logic [CNT_W-1:0] pend_val
);
    // Keep the latest deferred write until it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_val <= '0;
        end else if (consume) begin
            pend_vld <= 1'b0;
            pend_val <= '0;
        end else if (capture) begin
            pend_vld <= 1'b1;
            pend_val <= cap_val;
        end
    end
endmodule

// File: rtl/rptc_seq.sv
// Module: rptc_seq
// The sequencer core. In idle it accepts register loads and a start
// request. While running it pulses exec every cycle, counts the value
// down, and on the last iteration returns to idle and loads the
// completion value.
// Assumes: fin_val is valid in the cycle the count is zero.
module rptc_seq
    import rptc_pkg::*;
#(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] fin_val,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    rpt_state_e state;

    assign busy = (state == RPT_RUN);
    assign last = busy && (cnt == '0);

    // State, count and done pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RPT_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == RPT_IDLE) begin
                if (load)  cnt   <= load_val;
                if (start) state <= RPT_RUN;
            end else if (cnt == '0) begin
                state <= RPT_IDLE;
                cnt   <= fin_val;
                done  <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rptc_top.sv
// Module: rptc_top
// Instruction repeat sequencer with its count/flag register.
// Connects the write decoder, the deferred-write holder and the
// sequencer, and assembles the read value.
// Assumes: one register at a fixed address; the bus qualifies reg_wr
// with the address outside this block.
module rptc_top #(
    parameter int unsigned CNT_W = 13,
    parameter int unsigned REG_W = 16,
    localparam int unsigned NLANE = REG_W / 8,
    localparam int unsigned FLAG_POS = REG_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [NLANE-1:0] reg_be,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             start,
    output logic             exec,
    output logic             stall,
    output logic             done
);
    logic             wr_vld;
    logic [CNT_W-1:0] wr_cnt;
    logic             busy;
    logic             last;
    logic [CNT_W-1:0] cnt;
    logic             pend_vld;
    logic [CNT_W-1:0] pend_val;
    logic [CNT_W-1:0] fin_val;

    rptc_wrdec #(.CNT_W(CNT_W), .REG_W(REG_W)) u_dec (
        .wr     (reg_wr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .wr_vld (wr_vld),
        .wr_cnt (wr_cnt)
    );

    rptc_pend #(.CNT_W(CNT_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (wr_vld && busy),
        .cap_val  (wr_cnt),
        .consume  (last),
        .pend_vld (pend_vld),
        .pend_val (pend_val)
    );

    // Completion value: a write in the final cycle, else the held one, else zero.
    always_comb begin
        if (wr_vld)        fin_val = wr_cnt;
        else if (pend_vld) fin_val = pend_val;
        else               fin_val = '0;
    end

    rptc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (wr_vld && !busy),
        .load_val (wr_cnt),
        .fin_val  (fin_val),
        .busy     (busy),
        .last     (last),
        .cnt      (cnt),
        .done     (done)
    );

    assign exec  = busy;
    assign stall = busy && !last;

    // Read value: count field, flag bit, zeros elsewhere.
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[CNT_W-1:0]   = cnt;
        reg_rdata[FLAG_POS]    = busy;
    end
endmodule

// File: rtl/rptc_check.sv
// Module: rptc_check
// Port-level properties of the repeat sequencer, bound to rptc_top.
// Assumes: it sees only the top-level ports.
module rptc_check #(
    parameter int unsigned CNT_W = 13,
    parameter int unsigned REG_W = 16,
    localparam int unsigned NLANE = REG_W / 8,
    localparam int unsigned FLAG_POS = REG_W - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [NLANE-1:0] reg_be,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             start,
    input logic             exec,
    input logic             stall,
    input logic             done
);
    wire             flag = reg_rdata[FLAG_POS];
    wire [CNT_W-1:0] cval = reg_rdata[CNT_W-1:0];
    wire             wr_any = reg_wr && (|reg_be) && (|reg_wdata);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[FLAG_POS-1:CNT_W] == '0);

    a_r4_start_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && start) |=> (flag && exec));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cval != '0) |=> (flag && cval == $past(cval) - 1'b1));

    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cval == '0) |=> (done && !flag && !exec));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_stall_continues: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> exec);

    a_r8_start_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(exec) && $past(start)) |-> !exec);

    a_r9_write_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cval != '0 && wr_any) |=> (cval == $past(cval) - 1'b1));
endmodule

bind rptc_top rptc_check #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .start     (start),
    .exec      (exec),
    .stall     (stall),
    .done      (done)
);

// File: tb/rptc_top_test.sv
module rptc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        start = 1'b0;
    logic        exec, stall, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rptc_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
        .exec(exec), .stall(stall), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus write, sampled at the next rising edge; returns at a falling edge.
    task automatic bus_wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = 16'h0000;
    endtask

    // mode 0: plain; 1: start again while busy (R8); 2: writes while busy (R9)
    task automatic run_rep(input int n, input int mode);
        logic [15:0] fin;
        bus_wr(2'b11, 16'(n));
        chk("R3 full load", {16'h0, reg_rdata}, 32'(n));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int j = 0; j <= n; j++) begin
            chk("R4 exec", {31'h0, exec}, 32'h1);
            chk("R5 count/flag", {16'h0, reg_rdata}, 32'(16'h8000 | 16'(n - j)));
            chk("R7 stall", {31'h0, stall}, {31'h0, (n - j) != 0});
            chk("R6 no early done", {31'h0, done}, 32'h0);
            if (mode == 1) start = (j == 2);
            if (mode == 2) begin
                reg_wr = (j == 1 || j == 2);
                reg_be = (j == 1) ? 2'b11 : 2'b01;
                reg_wdata = (j == 1) ? 16'h0123 : 16'hAB55;
            end
            @(negedge clk);
        end
        start = 1'b0; reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = 16'h0;
        fin = (mode == 2) ? 16'h0055 : 16'h0000;
        chk("R6 done pulse", {31'h0, done}, 32'h1);
        chk("R4 exec ended", {31'h0, exec}, 32'h0);
        chk(mode == 2 ? "R9 deferred applied" : "R6 final readback", {16'h0, reg_rdata}, {16'h0, fin});
        @(negedge clk);
        chk("R6 done single", {31'h0, done}, 32'h0);
        chk(mode == 1 ? "R8 no rerun" : "R4 idle", {31'h0, exec}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rdata", {16'h0, reg_rdata}, 32'h0);
        chk("R1 reset outputs", {29'h0, exec, stall, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {16'h0, reg_rdata}, 32'h0);

        // R3: low lane sweep clears the high lane
        for (int v = 0; v < 256; v++) begin
            bus_wr(2'b11, 16'h1F00);
            bus_wr(2'b01, 16'(v) | 16'hFF00);
            chk("R3 low lane", {16'h0, reg_rdata}, 32'(v));
        end
        // R3/R2: high lane sweep clears low lane, top bits ignored
        for (int v = 0; v < 32; v++) begin
            bus_wr(2'b11, 16'h00FF);
            bus_wr(2'b10, 16'((v << 8) | 16'hE0A5));
            chk("R3 high lane", {16'h0, reg_rdata}, 32'(v << 8));
        end
        bus_wr(2'b11, 16'hFFFF);
        chk("R2 flag/reserved ignore writes", {16'h0, reg_rdata}, 32'h1FFF);
        bus_wr(2'b00, 16'h0000);
        chk("R3 no lanes no change", {16'h0, reg_rdata}, 32'h1FFF);

        for (int n = 0; n <= 40; n++) run_rep(n, 0);
        run_rep(8191, 0);
        run_rep(5, 1);
        run_rep(4, 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule